// File: doc/BRIEF.md
# Byte-Lane Dual-Port Pipelined RAM

This block is a true dual-port synchronous memory with 36-bit words. It has two fully independent ports, A and B. Each port has its own clock, reset, address, write data, read data and controls. Either port can read or write any word in any cycle. An access can touch any subset of four 9-bit lanes. Lane k covers word bits 9k to 9k+8, and each lane has its own active-low enable.

A port takes part in an access only while its active-low select is low and its active-high select is high. Every input is registered on the rising edge of the port clock. Read data then passes through a second output register. Pads are modelled as a read-data bus plus a per-lane drive vector. An asynchronous active-low output enable masks that vector without waiting for a clock edge.

The full part uses `ADDR_W = 14`, which gives 16384 words. The default build uses `ADDR_W = 10`.

Each port's capture stage is a small state machine with three states:
- `OP_IDLE` is entered on a deselect, or when no lane is enabled.
- `OP_READ` is entered when the port is selected with `rw` high.
- `OP_WRITE` is entered when the port is selected with `rw` low.

Each of these transitions is taken on every rising edge from any state. Reset forces `OP_IDLE`.

The same-cycle collision rules below hold when both ports run from one clock.

Top module: `lane_dpram`

## Requirements
- R1: A port is selected only when `cs_n` is 0 and `cs` is 1. A deselected cycle stores nothing and produces an all-zero `drive` at its output cycle.
- R2: A selected cycle with `rw` = 0 writes exactly the lanes whose `lane_en_n` bit is 0. Lane k is bits 9k..9k+8. The other lanes keep their contents.
- R3: A selected cycle with `rw` = 1 sets `drive[k]` only for lanes whose `lane_en_n[k]` is 0. It places the stored lane value on `rdata` bits 9k..9k+8, and undriven lanes of `rdata` read 0.
- R4: Read data and `drive` appear after the second rising edge following the edge that captured the address. The first edge is the input register and the second is the output register.
- R5: While `oe_n` is 1, `drive` is all zero with no clock edge needed. When `oe_n` returns to 0, the registered lanes reappear at once.
- R6: When one port reads a word in the same cycle that the other port writes it, the read returns the value held before the write.
- R7: When both ports write the same lane of the same word in one cycle, port A's data is stored. Different lanes written by the two ports in that cycle are both kept.
- R8: The output cycle that follows a write drives no lane.
- R9: A write is visible to a read on either port captured one edge later.
- R10: While reset is asserted, `drive` and `rdata` are zero on both ports.
- R11: Both ports can read the same word in the same cycle and both receive it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_n_a | input | 1 | Port A asynchronous reset, active low |
| cs_n_a | input | 1 | Port A select, active low |
| cs_a | input | 1 | Port A select, active high |
| rw_a | input | 1 | Port A direction: 1 read, 0 write |
| lane_en_n_a | input | LANES | Port A lane enables, active low |
| addr_a | input | ADDR_W | Port A word address |
| wdata_a | input | LANES*LANE_W | Port A write data |
| oe_n_a | input | 1 | Port A asynchronous output enable, active low |
| rdata_a | output | LANES*LANE_W | Port A read data, undriven lanes zero |
| drive_a | output | LANES | Port A per-lane pad drive enables |
| clk_b | input | 1 | Port B clock |
| rst_n_b | input | 1 | Port B asynchronous reset, active low |
| cs_n_b | input | 1 | Port B select, active low |
| cs_b | input | 1 | Port B select, active high |
| rw_b | input | 1 | Port B direction: 1 read, 0 write |
| lane_en_n_b | input | LANES | Port B lane enables, active low |
| addr_b | input | ADDR_W | Port B word address |
| wdata_b | input | LANES*LANE_W | Port B write data |
| oe_n_b | input | 1 | Port B asynchronous output enable, active low |
| rdata_b | output | LANES*LANE_W | Port B read data, undriven lanes zero |
| drive_b | output | LANES | Port B per-lane pad drive enables |

## Verification
The hardest situation to reach is two ports committing to the same word in the same cycle. Examples are a read against a write, or two writes to overlapping lanes. Reaching it needs both ports captured on one edge with matching addresses. The bench drives both clocks from a single source and places such pairs in directed steps. It also runs random traffic confined to eight words, so that overlapping lanes, partial enables and deselects collide often. The asynchronous output enable is probed between clock edges, while a read result is on the outputs.

// File: rtl/lane_dpram_pkg.sv
`timescale 1ns/1ps
// Shared types for the byte-lane dual-port RAM.
package lane_dpram_pkg;

    // Operation held by a port's capture stage.
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } port_op_e;

endpackage

// File: rtl/lane_dpram_front.sv
`timescale 1ns/1ps
// Capture stage of one port: registers address, data, lanes and the decoded op.
module lane_dpram_front
    import lane_dpram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cs_n,
    input  logic                     cs,
    input  logic                     rw,
    input  logic [LANES-1:0]         lane_en_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [LANES*LANE_W-1:0]  wdata,
    output port_op_e                 op_q,
    output logic [LANES-1:0]         lanes_q,
    output logic [ADDR_W-1:0]        addr_q,
    output logic [LANES*LANE_W-1:0]  wdata_q
);

    localparam int DATA_W = LANES * LANE_W;

    port_op_e op_d;
    logic     selected;
    logic     any_lane;

    assign selected = !cs_n && cs;
    assign any_lane = |(~lane_en_n);

    // Next-state decode.
    always_comb begin
        op_d = OP_IDLE;
        unique case ({selected && any_lane, rw})
            2'b11:   op_d = OP_READ;
            2'b10:   op_d = OP_WRITE;
            default: op_d = OP_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q <= OP_IDLE;
        end else begin
            op_q <= op_d;
        end
    end

    // Captured operands.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lanes_q <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            lanes_q <= ~lane_en_n;
            addr_q  <= addr;
            wdata_q <= wdata;
        end
    end

    logic [DATA_W-1:0] unused_width_tie;
    assign unused_width_tie = wdata_q;

endmodule

// File: rtl/lane_dpram_bank.sv
`timescale 1ns/1ps
// One storage bank, written by a single port, read at two addresses.
// The stored word is the XOR of the two banks at the same address.
module lane_dpram_bank #(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                     clk,
    input  logic [LANES-1:0]         wr_lanes,
    input  logic [ADDR_W-1:0]        waddr,
    input  logic [LANES*LANE_W-1:0]  wdata,
    input  logic [ADDR_W-1:0]        raddr_x,
    input  logic [ADDR_W-1:0]        raddr_y,
    output logic [LANES*LANE_W-1:0]  rdata_x,
    output logic [LANES*LANE_W-1:0]  rdata_y
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_lanes[g]) begin
                cells[waddr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata_x[g*LANE_W +: LANE_W] = cells[raddr_x];
        assign rdata_y[g*LANE_W +: LANE_W] = cells[raddr_y];
    end

endmodule

// File: rtl/lane_dpram_out.sv
`timescale 1ns/1ps
// Output pipeline register of one port with asynchronous output enable.
module lane_dpram_out #(
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_fire,
    input  logic [LANES-1:0]         rd_lanes,
    input  logic [LANES*LANE_W-1:0]  rd_word,
    input  logic                     oe_n,
    output logic [LANES*LANE_W-1:0]  rdata,
    output logic [LANES-1:0]         drive
);

    logic [LANES-1:0]        vld_q;
    logic [LANES*LANE_W-1:0] dat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            dat_q <= '0;
        end else begin
            vld_q <= rd_fire ? rd_lanes : '0;
            if (rd_fire) begin
                dat_q <= rd_word;
            end
        end
    end

    assign drive = vld_q & {LANES{~oe_n}};

    for (genvar g = 0; g < LANES; g++) begin : g_pad
        assign rdata[g*LANE_W +: LANE_W] = drive[g] ? dat_q[g*LANE_W +: LANE_W] : '0;
    end

endmodule

// File: rtl/lane_dpram.sv
`timescale 1ns/1ps
// Byte-lane true dual-port RAM with pipelined reads.
module lane_dpram
    import lane_dpram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                     clk_a,
    input  logic                     rst_n_a,
    input  logic                     cs_n_a,
    input  logic                     cs_a,
    input  logic                     rw_a,
    input  logic [LANES-1:0]         lane_en_n_a,
    input  logic [ADDR_W-1:0]        addr_a,
    input  logic [LANES*LANE_W-1:0]  wdata_a,
    input  logic                     oe_n_a,
    output logic [LANES*LANE_W-1:0]  rdata_a,
    output logic [LANES-1:0]         drive_a,
    input  logic                     clk_b,
    input  logic                     rst_n_b,
    input  logic                     cs_n_b,
    input  logic                     cs_b,
    input  logic                     rw_b,
    input  logic [LANES-1:0]         lane_en_n_b,
    input  logic [ADDR_W-1:0]        addr_b,
    input  logic [LANES*LANE_W-1:0]  wdata_b,
    input  logic                     oe_n_b,
    output logic [LANES*LANE_W-1:0]  rdata_b,
    output logic [LANES-1:0]         drive_b
);

    localparam int DATA_W = LANES * LANE_W;

    port_op_e          op_a, op_b;
    logic [LANES-1:0]  lanes_a, lanes_b;
    logic [ADDR_W-1:0] qaddr_a, qaddr_b;
    logic [DATA_W-1:0] qdata_a, qdata_b;

    lane_dpram_front #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_front_a (
        .clk(clk_a), .rst_n(rst_n_a), .cs_n(cs_n_a), .cs(cs_a), .rw(rw_a),
        .lane_en_n(lane_en_n_a), .addr(addr_a), .wdata(wdata_a),
        .op_q(op_a), .lanes_q(lanes_a), .addr_q(qaddr_a), .wdata_q(qdata_a)
    );

    lane_dpram_front #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_front_b (
        .clk(clk_b), .rst_n(rst_n_b), .cs_n(cs_n_b), .cs(cs_b), .rw(rw_b),
        .lane_en_n(lane_en_n_b), .addr(addr_b), .wdata(wdata_b),
        .op_q(op_b), .lanes_q(lanes_b), .addr_q(qaddr_b), .wdata_q(qdata_b)
    );

    // Bank contents seen at each port's captured address.
    logic [DATA_W-1:0] bka_at_a, bka_at_b, bkb_at_a, bkb_at_b;
    logic [DATA_W-1:0] word_a, word_b;
    logic [LANES-1:0]  wr_a, wr_b;
    logic              same_word;

    assign same_word = (qaddr_a == qaddr_b);
    assign wr_a = (op_a == OP_WRITE) ? lanes_a : '0;
    // Port B yields any lane that port A writes to the same word in this cycle.
    assign wr_b = (op_b == OP_WRITE) ? (lanes_b & ~(same_word ? wr_a : '0)) : '0;

    assign word_a = bka_at_a ^ bkb_at_a;
    assign word_b = bka_at_b ^ bkb_at_b;

    lane_dpram_bank #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_bank_a (
        .clk(clk_a), .wr_lanes(wr_a), .waddr(qaddr_a), .wdata(qdata_a ^ bkb_at_a),
        .raddr_x(qaddr_a), .raddr_y(qaddr_b), .rdata_x(bka_at_a), .rdata_y(bka_at_b)
    );

    lane_dpram_bank #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_bank_b (
        .clk(clk_b), .wr_lanes(wr_b), .waddr(qaddr_b), .wdata(qdata_b ^ bka_at_b),
        .raddr_x(qaddr_a), .raddr_y(qaddr_b), .rdata_x(bkb_at_a), .rdata_y(bkb_at_b)
    );

    lane_dpram_out #(.LANES(LANES), .LANE_W(LANE_W)) i_out_a (
        .clk(clk_a), .rst_n(rst_n_a), .rd_fire(op_a == OP_READ), .rd_lanes(lanes_a),
        .rd_word(word_a), .oe_n(oe_n_a), .rdata(rdata_a), .drive(drive_a)
    );

    lane_dpram_out #(.LANES(LANES), .LANE_W(LANE_W)) i_out_b (
        .clk(clk_b), .rst_n(rst_n_b), .rd_fire(op_b == OP_READ), .rd_lanes(lanes_b),
        .rd_word(word_b), .oe_n(oe_n_b), .rdata(rdata_b), .drive(drive_b)
    );

endmodule

// File: rtl/lane_dpram_chk.sv
`timescale 1ns/1ps
// Port-level properties of the dual-port RAM, bound to the top module.
module lane_dpram_chk #(
    parameter int LANES = 4
) (
    input logic             clk_a,
    input logic             rst_n_a,
    input logic             cs_n_a,
    input logic             cs_a,
    input logic             rw_a,
    input logic [LANES-1:0] lane_en_n_a,
    input logic             oe_n_a,
    input logic [LANES-1:0] drive_a,
    input logic             clk_b,
    input logic             rst_n_b,
    input logic             cs_n_b,
    input logic             cs_b,
    input logic             rw_b,
    input logic [LANES-1:0] lane_en_n_b,
    input logic             oe_n_b,
    input logic [LANES-1:0] drive_b
);

    // Edges seen since reset, saturating, so two-deep history is only used when valid.
    logic [1:0] age_a, age_b;

    always_ff @(posedge clk_a or negedge rst_n_a) begin
        if (!rst_n_a)          age_a <= '0;
        else if (age_a != 2'd3) age_a <= age_a + 2'd1;
    end

    always_ff @(posedge clk_b or negedge rst_n_b) begin
        if (!rst_n_b)          age_b <= '0;
        else if (age_b != 2'd3) age_b <= age_b + 2'd1;
    end

    AST_A_OE_MASKS: assert property (@(posedge clk_a) disable iff (!rst_n_a) oe_n_a |-> drive_a == '0); // R5
    AST_B_OE_MASKS: assert property (@(posedge clk_b) disable iff (!rst_n_b) oe_n_b |-> drive_b == '0); // R5

    AST_A_DESEL_QUIET: assert property (@(posedge clk_a) disable iff (!rst_n_a)
        (age_a >= 2'd2 && $past(!(!cs_n_a && cs_a), 2)) |-> drive_a == '0); // R1
    AST_B_DESEL_QUIET: assert property (@(posedge clk_b) disable iff (!rst_n_b)
        (age_b >= 2'd2 && $past(!(!cs_n_b && cs_b), 2)) |-> drive_b == '0); // R1

    AST_A_WRITE_QUIET: assert property (@(posedge clk_a) disable iff (!rst_n_a)
        (age_a >= 2'd2 && $past(!cs_n_a && cs_a && !rw_a, 2)) |-> drive_a == '0); // R8
    AST_B_WRITE_QUIET: assert property (@(posedge clk_b) disable iff (!rst_n_b)
        (age_b >= 2'd2 && $past(!cs_n_b && cs_b && !rw_b, 2)) |-> drive_b == '0); // R8

    AST_A_LANE_SUBSET: assert property (@(posedge clk_a) disable iff (!rst_n_a)
        (age_a >= 2'd2) |-> (drive_a & $past(lane_en_n_a, 2)) == '0); // R3
    AST_B_LANE_SUBSET: assert property (@(posedge clk_b) disable iff (!rst_n_b)
        (age_b >= 2'd2) |-> (drive_b & $past(lane_en_n_b, 2)) == '0); // R3

    AST_A_READ_LATENCY: assert property (@(posedge clk_a) disable iff (!rst_n_a)
        (age_a >= 2'd2 && !oe_n_a && $past(!cs_n_a && cs_a && rw_a, 2))
        |-> drive_a == ~$past(lane_en_n_a, 2)); // R4
    AST_B_READ_LATENCY: assert property (@(posedge clk_b) disable iff (!rst_n_b)
        (age_b >= 2'd2 && !oe_n_b && $past(!cs_n_b && cs_b && rw_b, 2))
        |-> drive_b == ~$past(lane_en_n_b, 2)); // R4

endmodule

bind lane_dpram lane_dpram_chk #(.LANES(LANES)) i_lane_dpram_chk (
    .clk_a(clk_a), .rst_n_a(rst_n_a), .cs_n_a(cs_n_a), .cs_a(cs_a), .rw_a(rw_a),
    .lane_en_n_a(lane_en_n_a), .oe_n_a(oe_n_a), .drive_a(drive_a),
    .clk_b(clk_b), .rst_n_b(rst_n_b), .cs_n_b(cs_n_b), .cs_b(cs_b), .rw_b(rw_b),
    .lane_en_n_b(lane_en_n_b), .oe_n_b(oe_n_b), .drive_b(drive_b)
);

// File: tb/test_lane_dpram.sv
`timescale 1ns/1ps
module test_lane_dpram;

    localparam int AW    = 10;
    localparam int NL    = 4;
    localparam int LW    = 9;
    localparam int DW    = NL * LW;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic          rst_n;
    logic          cs_n_a, cs_a, rw_a, oe_n_a, cs_n_b, cs_b, rw_b, oe_n_b;
    logic [NL-1:0] be_n_a, be_n_b, drive_a, drive_b;
    logic [AW-1:0] addr_a, addr_b;
    logic [DW-1:0] wdata_a, wdata_b, rdata_a, rdata_b;

    lane_dpram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) i_lane_dpram (
        .clk_a(clk), .rst_n_a(rst_n), .cs_n_a(cs_n_a), .cs_a(cs_a), .rw_a(rw_a),
        .lane_en_n_a(be_n_a), .addr_a(addr_a), .wdata_a(wdata_a), .oe_n_a(oe_n_a),
        .rdata_a(rdata_a), .drive_a(drive_a),
        .clk_b(clk), .rst_n_b(rst_n), .cs_n_b(cs_n_b), .cs_b(cs_b), .rw_b(rw_b),
        .lane_en_n_b(be_n_b), .addr_b(addr_b), .wdata_b(wdata_b), .oe_n_b(oe_n_b),
        .rdata_b(rdata_b), .drive_b(drive_b)
    );

    typedef struct packed {
        logic          cs_n;
        logic          cs;
        logic          rw;
        logic [NL-1:0] be_n;
        logic [AW-1:0] addr;
        logic [DW-1:0] d;
        logic          oe_n;
    } cmd_t;

    // Reference model state.
    logic [DW-1:0] m_val   [DEPTH];
    logic [NL-1:0] m_known [DEPTH];
    cmd_t          prev_a, prev_b, cur_a, cur_b;
    logic [NL-1:0] ev_a, ev_b, ek_a, ek_b, last_drv_a;
    logic [DW-1:0] ed_a, ed_b;
    string         etag, ptag;
    int            checks = 0;
    int            errors = 0;
    bit            done = 1'b0;

    function automatic cmd_t c_idle();
        cmd_t c = '0;
        c.cs_n = 1'b1; c.rw = 1'b1; c.be_n = '1;
        return c;
    endfunction

    function automatic cmd_t c_rd(logic [AW-1:0] a, logic [NL-1:0] be);
        cmd_t c = '0;
        c.rw = 1'b1; c.cs = 1'b1; c.be_n = be; c.addr = a;
        return c;
    endfunction

    function automatic cmd_t c_wr(logic [AW-1:0] a, logic [NL-1:0] be, logic [DW-1:0] d);
        cmd_t c = '0;
        c.cs = 1'b1; c.be_n = be; c.addr = a; c.d = d;
        return c;
    endfunction

    function automatic bit is_sel(cmd_t c);
        return !c.cs_n && c.cs;
    endfunction

    task automatic apply(cmd_t ca, cmd_t cb);
        cs_n_a = ca.cs_n; cs_a = ca.cs; rw_a = ca.rw; be_n_a = ca.be_n;
        addr_a = ca.addr; wdata_a = ca.d; oe_n_a = ca.oe_n;
        cs_n_b = cb.cs_n; cs_b = cb.cs; rw_b = cb.rw; be_n_b = cb.be_n;
        addr_b = cb.addr; wdata_b = cb.d; oe_n_b = cb.oe_n;
    endtask

    task automatic model_read(cmd_t c, output logic [NL-1:0] v, output logic [DW-1:0] d,
                              output logic [NL-1:0] k);
        v = '0; d = '0; k = '0;
        if (is_sel(c) && c.rw) begin
            v = ~c.be_n; d = m_val[c.addr]; k = m_known[c.addr];
        end
    endtask

    task automatic model_write(cmd_t c);
        if (is_sel(c) && !c.rw) begin
            for (int i = 0; i < NL; i++) begin
                if (!c.be_n[i]) begin
                    m_val[c.addr][i*LW +: LW] = c.d[i*LW +: LW];
                    m_known[c.addr][i] = 1'b1;
                end
            end
        end
    endtask

    task automatic check_port(string tag, string pn, logic [NL-1:0] drv, logic [DW-1:0] rd,
                              logic [NL-1:0] v, logic [DW-1:0] d, logic [NL-1:0] k, logic oe_n);
        logic [NL-1:0] xd;
        logic [DW-1:0] xw;
        xd = v & {NL{~oe_n}};
        checks++;
        if (drv !== xd) begin
            errors++;
            $display("FAIL %s port %s drive: got %b expected %b", tag, pn, drv, xd);
        end
        for (int i = 0; i < NL; i++)
            xw[i*LW +: LW] = !xd[i] ? '0 : (k[i] ? d[i*LW +: LW] : rd[i*LW +: LW]);
        checks++;
        if (rd !== xw) begin
            errors++;
            $display("FAIL %s port %s rdata: got %h expected %h", tag, pn, rd, xw);
        end
    endtask

    // One cycle: compare outputs against the model, drive new inputs, advance the model.
    task automatic step(cmd_t ca, cmd_t cb, string tag);
        @(negedge clk);
        check_port(etag, "A", drive_a, rdata_a, ev_a, ed_a, ek_a, cur_a.oe_n);
        check_port(etag, "B", drive_b, rdata_b, ev_b, ed_b, ek_b, cur_b.oe_n);
        last_drv_a = drive_a;
        apply(ca, cb);
        cur_a = ca; cur_b = cb;
        model_read(prev_a, ev_a, ed_a, ek_a);
        model_read(prev_b, ev_b, ed_b, ek_b);
        model_write(prev_b);
        model_write(prev_a);   // port A wins a same-lane collision
        etag = ptag; ptag = tag;
        prev_a = ca; prev_b = cb;
    endtask

    // Output enable acts between edges (R5).
    task automatic oe_probe();
        oe_n_a = 1'b1;
        #0.5;
        checks++;
        if (drive_a !== '0) begin
            errors++;
            $display("FAIL R5 async mask: got %b expected %b", drive_a, {NL{1'b0}});
        end
        oe_n_a = cur_a.oe_n;
        #0.5;
        checks++;
        if (drive_a !== last_drv_a || last_drv_a == '0) begin
            errors++;
            $display("FAIL R5 async restore: got %b expected %b (nonzero)", drive_a, last_drv_a);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        cmd_t ta, tb;
        for (int i = 0; i < DEPTH; i++) begin
            m_val[i] = '0; m_known[i] = '0;
        end
        prev_a = c_idle(); prev_b = c_idle(); cur_a = c_idle(); cur_b = c_idle();
        ev_a = '0; ev_b = '0; ek_a = '0; ek_b = '0; ed_a = '0; ed_b = '0;
        last_drv_a = '0;
        etag = "R10"; ptag = "R10";
        rst_n = 1'b0;
        apply(c_rd(10'd5, 4'b0000), c_rd(10'd5, 4'b0000));
        repeat (3) @(negedge clk);
        checks++;
        if (drive_a !== '0 || drive_b !== '0 || rdata_a !== '0 || rdata_b !== '0) begin
            errors++;
            $display("FAIL R10 reset outputs: got %b/%b expected 0000/0000", drive_a, drive_b);
        end
        apply(c_idle(), c_idle());
        rst_n = 1'b1;

        // R2 full write, then R11 both ports read it
        step(c_wr(10'd5, 4'b0000, 36'h1_2345_6789), c_idle(), "R8");
        step(c_idle(), c_idle(), "R10");
        step(c_rd(10'd5, 4'b0000), c_rd(10'd5, 4'b0000), "R11");
        // R9 write on A, read on B one edge later
        step(c_wr(10'd6, 4'b0000, 36'hA_BCDE_F012), c_idle(), "R9");
        step(c_idle(), c_rd(10'd6, 4'b0000), "R9");
        // R2 partial write of lane 1 only
        step(c_idle(), c_wr(10'd5, 4'b1101, 36'hF_FFFF_FFFF), "R2");
        step(c_rd(10'd5, 4'b0000), c_idle(), "R2");
        // R3 read lanes 0 and 2 only
        step(c_rd(10'd5, 4'b1010), c_rd(10'd6, 4'b0111), "R3");
        // R6 read by A against write by B, same word, same cycle
        step(c_rd(10'd5, 4'b0000), c_wr(10'd5, 4'b0000, 36'h0_5555_AAAA), "R6");
        step(c_rd(10'd5, 4'b0000), c_idle(), "R9");
        // R7 same-lane collision and merged lanes
        step(c_wr(10'd7, 4'b0000, 36'h1_1111_1111), c_wr(10'd7, 4'b0000, 36'h2_2222_2222), "R7");
        step(c_wr(10'd8, 4'b1100, 36'h3_3333_3333), c_wr(10'd8, 4'b0011, 36'h4_4444_4444), "R7");
        step(c_rd(10'd7, 4'b0000), c_rd(10'd8, 4'b0000), "R7");
        step(c_rd(10'd8, 4'b0000), c_rd(10'd7, 4'b0000), "R7");
        // R1 deselected writes and reads
        ta = c_wr(10'd5, 4'b0000, 36'h9_9999_9999); ta.cs_n = 1'b1;
        tb = c_wr(10'd5, 4'b0000, 36'h8_8888_8888); tb.cs = 1'b0;
        step(ta, tb, "R1");
        ta = c_rd(10'd5, 4'b0000); ta.cs = 1'b0;
        tb = c_rd(10'd5, 4'b0000); tb.cs_n = 1'b1;
        step(ta, tb, "R1");
        step(c_rd(10'd5, 4'b0000), c_rd(10'd5, 4'b0000), "R1");
        // R5 output enable: synchronous use and an asynchronous probe
        step(c_rd(10'd6, 4'b0100), c_idle(), "R5");
        step(c_idle(), c_idle(), "R5");
        step(c_idle(), c_idle(), "R5");
        oe_probe();
        step(c_rd(10'd6, 4'b0000), c_idle(), "R5");
        ta = c_idle(); ta.oe_n = 1'b1;
        step(ta, c_idle(), "R5");
        step(c_idle(), c_idle(), "R5");

        // R4 random traffic on eight words
        for (int n = 0; n < 400; n++) begin
            ta = ($urandom % 2) ? c_rd(AW'($urandom % 8), NL'($urandom))
                                : c_wr(AW'($urandom % 8), NL'($urandom), DW'({$urandom, $urandom}));
            tb = ($urandom % 2) ? c_rd(AW'($urandom % 8), NL'($urandom))
                                : c_wr(AW'($urandom % 8), NL'($urandom), DW'({$urandom, $urandom}));
            if ($urandom % 10 == 0) ta.cs_n = 1'b1;
            if ($urandom % 10 == 0) tb.cs = 1'b0;
            if ($urandom % 8 == 0) ta.oe_n = 1'b1;
            if ($urandom % 8 == 0) tb.oe_n = 1'b1;
            step(ta, tb, "R4");
        end
        step(c_idle(), c_idle(), "R4");
        step(c_idle(), c_idle(), "R4");
        step(c_idle(), c_idle(), "R4");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule